// File: doc/BRIEF.md
# Capacity-Limited Bundled Crossbar

This block is an S-by-S switch whose ports are bundles rather than single wires. Each input bundle and each output bundle holds K message lanes. A message on an input lane carries a valid bit, an output-bundle request and a payload. All messages that name the same output bundle are delivered together, side by side in that bundle's lanes, as long as there are no more than K of them. When an output is oversubscribed, K messages are accepted and the rest are refused. Refused messages are dropped, and the sender learns this from a per-lane flag.

Contention is settled by a fixed order. The order is set by a global message index n = bundle*K + lane, and a lower index wins. Winners fill the output lanes from lane 0 upward in that same order. The switch is one stage deep. The inputs of one cycle appear, together with their grant and refuse flags, on the registered outputs after the next rising clock edge. The reset is asserted asynchronously and released through a two-flop synchronizer.

Top module: `hyperbar_switch`

## Requirements
- R1: While reset is held, and in the cycle after reset is asserted, every output lane has valid low and payload zero, and every grant and refuse bit is low.
- R2: An accepted message's payload appears on a lane of the output bundle named by its request, one clock edge after the message is presented. The request of message n sits in in_req bits [n*RW +: RW].
- R3: When at most K valid messages request one output, all of them are accepted, with no loss.
- R4: When more than K valid messages request one output, exactly K are accepted and the others are refused.
- R5: Among competitors for one output, the K messages with the lowest global index n = bundle*K + lane are accepted.
- R6: Output bundle o drives its winners on lanes o*K+0, o*K+1, and so on, in increasing n. Lanes it does not fill drive valid low and payload zero.
- R7: grant[n] is high exactly when message n was valid and accepted. refuse[n] is high exactly when it was valid and not accepted. Both are low for idle lanes. Both are aligned with the output data.
- R8: A lane with valid low is ignored. Its request field takes no capacity from any output and changes no other message's outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | S*K | Valid bit per input lane, bit n = bundle*K+lane |
| in_req | input | S*K*RW | Requested output bundle per lane, RW bits each |
| in_data | input | S*K*PW | Payload per lane, PW bits each |
| out_valid | output | S*K | Valid bit per output lane, bit o*K+l |
| out_data | output | S*K*PW | Payload per output lane |
| grant | output | S*K | Message on input lane n was accepted |
| refuse | output | S*K | Message on input lane n was valid but dropped |

## Verification
The hardest case to reach is an output that is oversubscribed while other outputs are lightly loaded. In that case the cut at K must fall on the right index, and it must not disturb the packing of other bundles. Idle lanes that carry a request for the crowded output must also be ignored. The bench drives vectors that flood one output with every lane, and vectors that mix idle lanes requesting a saturated output. It runs these on a 2x2 and a 4x3 instance, and it also drives a long run of random traffic on the 4x3 instance. Each result is compared against a counting model.

// File: rtl/hb_pkg.sv
package hb_pkg;
  // Width of an index that selects one of v items (at least one bit).
  function automatic int idx_w(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/hb_rst_sync.sv
module hb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_q_n = stage_q[1];
endmodule

// File: rtl/hb_rank.sv
// Per-output ranking: each requester gets the count of earlier requesters,
// and it wins while that count is below the capacity.
module hb_rank #(
  parameter int N  = 4,
  parameter int K  = 2,
  parameter int CW = 3
) (
  input  logic [N-1:0]    match_i,
  output logic [N*CW-1:0] rank_o,
  output logic [N-1:0]    win_o
);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt    = '0;
    rank_o = '0;
    win_o  = '0;
    for (int n = 0; n < N; n++) begin
      rank_o[n*CW +: CW] = cnt;
      win_o[n]           = match_i[n] && (cnt < CW'(K));
      if (match_i[n]) cnt = cnt + CW'(1);
    end
  end
endmodule

// File: rtl/hb_pack.sv
// Lane packer: lane l of a bundle takes the winner whose rank equals l.
module hb_pack #(
  parameter int N  = 4,
  parameter int K  = 2,
  parameter int CW = 3,
  parameter int PW = 8
) (
  input  logic [N-1:0]    win_i,
  input  logic [N*CW-1:0] rank_i,
  input  logic [N*PW-1:0] data_i,
  output logic [K-1:0]    valid_o,
  output logic [K*PW-1:0] data_o
);
  always_comb begin
    valid_o = '0;
    data_o  = '0;
    for (int l = 0; l < K; l++) begin
      for (int n = 0; n < N; n++) begin
        if (win_i[n] && (rank_i[n*CW +: CW] == CW'(l))) begin
          valid_o[l]         = 1'b1;
          data_o[l*PW +: PW] = data_o[l*PW +: PW] | data_i[n*PW +: PW];
        end
      end
    end
  end
endmodule

// File: rtl/hyperbar_switch.sv
module hyperbar_switch #(
  parameter int S  = 4,
  parameter int K  = 2,
  parameter int PW = 16,
  localparam int N  = S * K,
  localparam int RW = hb_pkg::idx_w(S),
  localparam int CW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    in_valid,
  input  logic [N*RW-1:0] in_req,
  input  logic [N*PW-1:0] in_data,
  output logic [N-1:0]    out_valid,
  output logic [N*PW-1:0] out_data,
  output logic [N-1:0]    grant,
  output logic [N-1:0]    refuse
);
  logic rst_q_n;

  hb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  // Request decode: which messages target each output bundle.
  logic [N-1:0]    match   [S];
  logic [N-1:0]    win     [S];
  logic [N*CW-1:0] rank    [S];
  logic [K-1:0]    bund_v  [S];
  logic [K*PW-1:0] bund_d  [S];

  always_comb begin
    for (int o = 0; o < S; o++) begin
      for (int n = 0; n < N; n++) begin
        match[o][n] = in_valid[n] && (in_req[n*RW +: RW] == RW'(o));
      end
    end
  end

  for (genvar o = 0; o < S; o++) begin : g_out
    hb_rank #(.N(N), .K(K), .CW(CW)) u_rank (
      .match_i (match[o]),
      .rank_o  (rank[o]),
      .win_o   (win[o])
    );
    hb_pack #(.N(N), .K(K), .CW(CW), .PW(PW)) u_pack (
      .win_i   (win[o]),
      .rank_i  (rank[o]),
      .data_i  (in_data),
      .valid_o (bund_v[o]),
      .data_o  (bund_d[o])
    );
  end

  // Next-state assembly.
  logic [N-1:0]    nxt_valid, nxt_grant, nxt_refuse;
  logic [N*PW-1:0] nxt_data;

  always_comb begin
    nxt_grant = '0;
    for (int o = 0; o < S; o++) begin
      nxt_grant              = nxt_grant | win[o];
      nxt_valid[o*K +: K]    = bund_v[o];
      nxt_data[o*K*PW +: K*PW] = bund_d[o];
    end
    nxt_refuse = in_valid & ~nxt_grant;
  end

  // Registers.
  logic [N-1:0]    out_valid_q, grant_q, refuse_q;
  logic [N*PW-1:0] out_data_q;
  logic            live_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid_q <= '0;
      out_data_q  <= '0;
      grant_q     <= '0;
      refuse_q    <= '0;
      live_q      <= 1'b0;
    end else begin
      out_valid_q <= nxt_valid;
      out_data_q  <= nxt_data;
      grant_q     <= nxt_grant;
      refuse_q    <= nxt_refuse;
      live_q      <= 1'b1;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign grant     = grant_q;
  assign refuse    = refuse_q;

  // Assertions.
  a_r7_outcome_covers_valid: assert property (@(posedge clk) disable iff (!rst_q_n)
    live_q |-> ((grant_q | refuse_q) == $past(in_valid)));

  a_r3_lanes_match_grants: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(out_valid_q) == $countones(grant_q));

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r6_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
      !out_valid_q[i] |-> (out_data_q[i*PW +: PW] == '0));
    if ((i % K) != 0) begin : g_pk
      a_r6_lanes_packed: assert property (@(posedge clk) disable iff (!rst_q_n)
        out_valid_q[i] |-> out_valid_q[i-1]);
    end
  end
endmodule

// File: tb/tb_hyperbar_switch.sv
module tb_hyperbar_switch;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int S0 = 2, K0 = 2, N0 = S0*K0, R0 = 1;
  localparam int S1 = 4, K1 = 3, N1 = S1*K1, R1W = 2;

  // {valid[3:0], req bits[3:0]} ; req bit n is the request of message n
  localparam logic [7:0] SMALL_VEC [10] = '{
    8'b0000_0000, 8'b1111_0000, 8'b1111_1111, 8'b1111_0101, 8'b1010_0000,
    8'b0100_0100, 8'b0111_0000, 8'b1110_1110, 8'b0001_0001, 8'b1100_0011
  };

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N0-1:0]    s_valid, s_ov, s_gr, s_rf;
  logic [N0*R0-1:0] s_req;
  logic [N0*PW-1:0] s_data, s_od;
  logic [N1-1:0]    b_valid, b_ov, b_gr, b_rf;
  logic [N1*R1W-1:0] b_req;
  logic [N1*PW-1:0] b_data, b_od;

  hyperbar_switch #(.S(S0), .K(K0), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_req(s_req), .in_data(s_data),
    .out_valid(s_ov), .out_data(s_od), .grant(s_gr), .refuse(s_rf));

  hyperbar_switch #(.S(S1), .K(K1), .PW(PW)) dut_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_req(b_req), .in_data(b_data),
    .out_valid(b_ov), .out_data(b_od), .grant(b_gr), .refuse(b_rf));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference counting model.
  task automatic model(input int s, input int k, input logic [15:0] v, input int rq[16],
                       input logic [7:0] pay[16], output logic [15:0] ev,
                       output logic [15:0] eg, output logic [15:0] er,
                       output logic [127:0] ed);
    ev = '0; eg = '0; er = '0; ed = '0;
    for (int o = 0; o < s; o++) begin
      int cnt = 0;
      for (int n = 0; n < s*k; n++) begin
        if (v[n] && rq[n] == o) begin
          if (cnt < k) begin
            eg[n] = 1'b1;
            ev[o*k+cnt] = 1'b1;
            ed[(o*k+cnt)*PW +: PW] = pay[n];
            cnt++;
          end else begin
            er[n] = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic run_small(input logic [3:0] v, input logic [3:0] rb, input int tagv);
    int rq[16]; logic [7:0] pay[16];
    logic [15:0] ev, eg, er; logic [127:0] ed;
    for (int n = 0; n < 16; n++) begin rq[n] = 0; pay[n] = '0; end
    @(negedge clk);
    for (int n = 0; n < N0; n++) begin
      rq[n] = int'(rb[n]);
      pay[n] = 8'(tagv*16 + n + 1);
      s_data[n*PW +: PW] = pay[n];
    end
    s_valid = v; s_req = rb;
    @(posedge clk); #1;
    model(S0, K0, 16'(v), rq, pay, ev, eg, er, ed);
    chk("R2/R6 small lane valid", 128'(s_ov), 128'(ev));
    chk("R2/R5/R6 small lane data", 128'(s_od), ed);
    chk("R3/R7 small grant", 128'(s_gr), 128'(eg));
    chk("R4/R7 small refuse", 128'(s_rf), 128'(er));
  endtask

  task automatic run_wide(input logic [11:0] v, input int rin[12], input int tagv);
    int rq[16]; logic [7:0] pay[16];
    logic [15:0] ev, eg, er; logic [127:0] ed;
    for (int n = 0; n < 16; n++) begin rq[n] = 0; pay[n] = '0; end
    @(negedge clk);
    for (int n = 0; n < N1; n++) begin
      rq[n] = rin[n];
      pay[n] = 8'(tagv*13 + n + 1);
      b_data[n*PW +: PW] = pay[n];
      b_req[n*R1W +: R1W] = R1W'(rin[n]);
    end
    b_valid = v;
    @(posedge clk); #1;
    model(S1, K1, 16'(v), rq, pay, ev, eg, er, ed);
    chk("R2/R6 wide lane valid", 128'(b_ov), 128'(ev));
    chk("R2/R5/R6 wide lane data", 128'(b_od), ed);
    chk("R3/R7 wide grant", 128'(b_gr), 128'(eg));
    chk("R4/R7 wide refuse", 128'(b_rf), 128'(er));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rin[12];
    rst_n = 1'b0;
    s_valid = '0; s_req = '0; s_data = '0;
    b_valid = '0; b_req = '0; b_data = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 reset valid", 128'({s_ov, b_ov}), 128'(0));
    chk("R1 reset data", 128'({s_od, b_od}), 128'(0));
    chk("R1 reset flags", 128'({s_gr, s_rf, b_gr, b_rf}), 128'(0));
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // Table walk on the 2x2 instance.
    for (int i = 0; i < 10; i++) run_small(SMALL_VEC[i][7:4], SMALL_VEC[i][3:0], i);

    // R4/R5: all twelve lanes flood output 2 on the 4x3 instance.
    for (int n = 0; n < N1; n++) rin[n] = 2;
    run_wide(12'hFFF, rin, 1);
    chk("R4 flood grants lowest three", 128'(b_gr), 128'(12'h007));
    chk("R4 flood refuses rest", 128'(b_rf), 128'(12'hFF8));

    // R8: idle lanes request output 0; one valid message still gets lane 0.
    for (int n = 0; n < N1; n++) rin[n] = 0;
    run_wide(12'h800, rin, 2);
    chk("R8 idle requests ignored", 128'(b_ov[2:0]), 128'(3'b001));
    chk("R8 idle payload", 128'(b_od[PW-1:0]), 128'(8'(2*13 + 11 + 1)));

    // R3: exactly K per output, all accepted.
    for (int n = 0; n < N1; n++) rin[n] = n % S1;
    run_wide(12'hFFF, rin, 3);
    chk("R3 full but not over", 128'(b_rf), 128'(0));

    // Random traffic on the 4x3 instance.
    for (int t = 0; t < 60; t++) begin
      logic [11:0] v;
      v = 12'($urandom);
      for (int n = 0; n < N1; n++) rin[n] = int'($urandom % 4);
      run_wide(v, rin, t + 4);
    end

    // R1: asynchronous reset during traffic clears outputs.
    for (int n = 0; n < N1; n++) rin[n] = 1;
    run_wide(12'h0FF, rin, 5);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 mid-run reset valid", 128'({s_ov, b_ov}), 128'(0));
    chk("R1 mid-run reset flags", 128'({s_gr, s_rf, b_gr, b_rf}), 128'(0));

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule